// File: doc/BRIEF.md
# CAN Receive Mailbox Matching Engine

This block decides where an incoming CAN frame is stored once its identifier is known. Two kinds of destination compete for each frame. One is a small receive FIFO guarded by a set of acceptance filters. The other is a bank of individually programmed message buffers. Each message buffer carries a 4-bit state code, a 29-bit identifier and a 29-bit mask. Each filter carries an enable, an identifier and a mask. Payload storage, bit timing and the host bus lie outside the block. The block tracks the FIFO fill level and takes pop requests from the host. For every frame it emits a one-cycle store strobe that names the target. If the frame was meant for the FIFO, the FIFO is full and no mailbox takes the frame, it emits an overflow strobe instead.

Frames enter through a valid/ready stream input. `frame_ready` is low while reset is active and during the first clock after reset is released. After that it stays high, and one frame is taken on every clock in which `frame_valid` is high. A frame offered while `frame_ready` is low is not taken and must be held by the sender. Host configuration (mailbox writes, filter writes, the scan-order bit and FIFO pops) uses plain single-cycle pins.

Top module: `can_rx_match`

## Requirements
- R1: After reset every mailbox reads back code 4'h0 (inactive), every filter is disabled, `fifo_count` is 0, and `store_valid` and `fifo_overflow` are low.
- R2: Only a mailbox whose code is 4'h1 (receive empty) can take a frame. Codes 4'h0 (inactive), 4'h2 (receive full) and 4'h4 (transmit inactive) never match.
- R3: A mailbox or an enabled filter matches when ((frame_id XOR stored id) AND stored mask) is zero over all 29 bits.
- R4: Within each structure the lowest-numbered matching entry wins.
- R5: With `cfg_fifo_first` = 1, the filters are tried first. If no filter matches, or the FIFO is full, the mailboxes are tried next.
- R6: With `cfg_fifo_first` = 0, the mailboxes are tried first. If no mailbox matches, the filters are tried next.
- R7: When `fifo_count` equals the FIFO depth (6), the FIFO is not a candidate. A matching mailbox takes the frame and `fifo_overflow` stays low.
- R8: `fifo_overflow` pulses for one cycle, with no store strobe, when a frame matches an enabled filter, the FIFO is full and no mailbox matches.
- R9: A capture sets the mailbox code to 4'h2. The mailbox then takes no further frame until the host writes its code back to 4'h1.
- R10: The store or overflow strobe for a frame taken at clock edge k appears after edge k+1 and lasts exactly one cycle. `store_to_fifo` = 1 means `store_index` is a filter number. `store_to_fifo` = 0 means it is a mailbox number.
- R11: A FIFO store raises `fifo_count` by 1. `fifo_pop` lowers it by 1, and a pop is ignored when the count is 0. A store and a pop in the same cycle leave the count unchanged. After an overflow the FIFO takes nothing until a pop frees an entry.
- R12: If a host write and a capture hit the same mailbox in the same cycle, the host's code is the one kept.
- R13: If the FIFO has room and no candidate matches, the frame is dropped with neither strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fifo_first | input | 1 | 1: filters are scanned before mailboxes |
| frame_valid | input | 1 | Frame identifier is offered |
| frame_ready | output | 1 | Block takes the offered frame |
| frame_id | input | 29 | Received identifier |
| mb_wr_en | input | 1 | Host mailbox write strobe |
| mb_wr_idx | input | 4 | Mailbox being written |
| mb_wr_code | input | 4 | New mailbox code |
| mb_wr_id | input | 29 | New mailbox identifier |
| mb_wr_mask | input | 29 | New mailbox mask |
| flt_wr_en | input | 1 | Host filter write strobe |
| flt_wr_idx | input | 3 | Filter being written |
| flt_wr_on | input | 1 | Filter enable value |
| flt_wr_id | input | 29 | New filter identifier |
| flt_wr_mask | input | 29 | New filter mask |
| fifo_pop | input | 1 | Host removes one FIFO entry |
| mb_rd_idx | input | 4 | Mailbox whose code is read back |
| mb_rd_code | output | 4 | Code of the selected mailbox |
| store_valid | output | 1 | One-cycle store strobe |
| store_to_fifo | output | 1 | Target is the FIFO |
| store_index | output | 4 | Filter or mailbox number of the target |
| fifo_overflow | output | 1 | One-cycle overflow strobe |
| fifo_count | output | 3 | FIFO entries in use |

## Verification
Two events can fall in the same cycle: a capture into a mailbox, and a host rewrite of that same mailbox. The bench provokes this by offering a frame that matches a receive-empty mailbox and, on the next clock, writing that same mailbox. The outcome is judged at the mailbox read-back port, where the host's code must remain and the capture's receive-full mark must not appear. The same timing is used to line up a FIFO store with a host pop. The count must then stay where it was. The bench's behavioural model computes both outcomes and compares them every clock.

// File: rtl/can_rx_match_pkg.sv
`timescale 1ns/1ps
package can_rx_match_pkg;
  localparam int ID_W = 29;
  typedef logic [3:0] mb_code_t;
  localparam mb_code_t CODE_INACTIVE = 4'h0;
  localparam mb_code_t CODE_RX_EMPTY = 4'h1;
  localparam mb_code_t CODE_RX_FULL  = 4'h2;
  localparam mb_code_t CODE_TX_IDLE  = 4'h4;
endpackage

// File: rtl/can_rx_first_hit.sv
`timescale 1ns/1ps
// Lowest-index-wins selector over a hit vector.
module can_rx_first_hit #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  hit,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/can_rx_mb_bank.sv
`timescale 1ns/1ps
// Mailbox state: code, identifier and mask per entry, plus match vector.
module can_rx_mb_bank
  import can_rx_match_pkg::*;
#(
  parameter int NMB = 16,
  parameter int IW  = $clog2(NMB)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  mb_code_t        wr_code,
  input  logic [ID_W-1:0] wr_id,
  input  logic [ID_W-1:0] wr_mask,
  input  logic            cap_en,
  input  logic [IW-1:0]   cap_idx,
  input  logic [ID_W-1:0] frame_id,
  output logic [NMB-1:0]  hit,
  input  logic [IW-1:0]   rd_idx,
  output mb_code_t        rd_code
);
  mb_code_t        code_q [NMB];
  logic [ID_W-1:0] id_q   [NMB];
  logic [ID_W-1:0] mask_q [NMB];

  for (genvar g = 0; g < NMB; g++) begin : g_mb
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        code_q[g] <= CODE_INACTIVE;
        id_q[g]   <= '0;
        mask_q[g] <= '0;
      end else if (wr_en && wr_idx == IW'(g)) begin
        code_q[g] <= wr_code;           // host write beats capture
        id_q[g]   <= wr_id;
        mask_q[g] <= wr_mask;
      end else if (cap_en && cap_idx == IW'(g)) begin
        code_q[g] <= CODE_RX_FULL;
      end
    end

    assign hit[g] = (code_q[g] == CODE_RX_EMPTY) &&
                    (((frame_id ^ id_q[g]) & mask_q[g]) == '0);
  end

  assign rd_code = code_q[rd_idx];

  AST_CAP_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |-> code_q[cap_idx] == CODE_RX_EMPTY);  // R2

  AST_CAP_MARKS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && !(wr_en && wr_idx == cap_idx)) |=> code_q[$past(cap_idx)] == CODE_RX_FULL);  // R9

  AST_HOST_WRITE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> code_q[$past(wr_idx)] == $past(wr_code));  // R12
endmodule

// File: rtl/can_rx_filter_bank.sv
`timescale 1ns/1ps
// FIFO acceptance filters: enable, identifier and mask per entry.
module can_rx_filter_bank
  import can_rx_match_pkg::*;
#(
  parameter int NFLT = 8,
  parameter int IW   = $clog2(NFLT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic            wr_on,
  input  logic [ID_W-1:0] wr_id,
  input  logic [ID_W-1:0] wr_mask,
  input  logic [ID_W-1:0] frame_id,
  output logic [NFLT-1:0] hit
);
  logic            on_q   [NFLT];
  logic [ID_W-1:0] id_q   [NFLT];
  logic [ID_W-1:0] mask_q [NFLT];

  for (genvar g = 0; g < NFLT; g++) begin : g_flt
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        on_q[g]   <= 1'b0;
        id_q[g]   <= '0;
        mask_q[g] <= '0;
      end else if (wr_en && wr_idx == IW'(g)) begin
        on_q[g]   <= wr_on;
        id_q[g]   <= wr_id;
        mask_q[g] <= wr_mask;
      end
    end

    assign hit[g] = on_q[g] && (((frame_id ^ id_q[g]) & mask_q[g]) == '0);
  end
endmodule

// File: rtl/can_rx_match.sv
`timescale 1ns/1ps
module can_rx_match
  import can_rx_match_pkg::*;
#(
  parameter int NMB        = 16,
  parameter int NFLT       = 8,
  parameter int FIFO_DEPTH = 6,
  localparam int MB_IW  = $clog2(NMB),
  localparam int FL_IW  = $clog2(NFLT),
  localparam int IDX_W  = (MB_IW > FL_IW) ? MB_IW : FL_IW,
  localparam int CNT_W  = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_fifo_first,
  input  logic             frame_valid,
  output logic             frame_ready,
  input  logic [28:0]      frame_id,
  input  logic             mb_wr_en,
  input  logic [MB_IW-1:0] mb_wr_idx,
  input  logic [3:0]       mb_wr_code,
  input  logic [28:0]      mb_wr_id,
  input  logic [28:0]      mb_wr_mask,
  input  logic             flt_wr_en,
  input  logic [FL_IW-1:0] flt_wr_idx,
  input  logic             flt_wr_on,
  input  logic [28:0]      flt_wr_id,
  input  logic [28:0]      flt_wr_mask,
  input  logic             fifo_pop,
  input  logic [MB_IW-1:0] mb_rd_idx,
  output logic [3:0]       mb_rd_code,
  output logic             store_valid,
  output logic             store_to_fifo,
  output logic [IDX_W-1:0] store_index,
  output logic             fifo_overflow,
  output logic [CNT_W-1:0] fifo_count
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(FIFO_DEPTH);

  // stage 1: frame capture
  logic            rdy_q, pend_q;
  logic [ID_W-1:0] pend_id_q;
  wire             accept = frame_valid && rdy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q     <= 1'b0;
      pend_q    <= 1'b0;
      pend_id_q <= '0;
    end else begin
      rdy_q  <= 1'b1;
      pend_q <= accept;
      if (accept) pend_id_q <= frame_id;
    end
  end
  assign frame_ready = rdy_q;

  // match structures
  logic [NMB-1:0]   mb_hit;
  logic [NFLT-1:0]  fl_hit;
  logic             mb_any, fl_any;
  logic [MB_IW-1:0] mb_sel;
  logic [FL_IW-1:0] fl_sel;
  logic             take_fifo, take_mb, ovf_now, fifo_room;
  logic [CNT_W-1:0] cnt_q;

  can_rx_mb_bank #(.NMB(NMB), .IW(MB_IW)) u_mb (
    .clk(clk), .rst_n(rst_n),
    .wr_en(mb_wr_en), .wr_idx(mb_wr_idx), .wr_code(mb_wr_code),
    .wr_id(mb_wr_id), .wr_mask(mb_wr_mask),
    .cap_en(take_mb), .cap_idx(mb_sel),
    .frame_id(pend_id_q), .hit(mb_hit),
    .rd_idx(mb_rd_idx), .rd_code(mb_rd_code)
  );

  can_rx_filter_bank #(.NFLT(NFLT), .IW(FL_IW)) u_flt (
    .clk(clk), .rst_n(rst_n),
    .wr_en(flt_wr_en), .wr_idx(flt_wr_idx), .wr_on(flt_wr_on),
    .wr_id(flt_wr_id), .wr_mask(flt_wr_mask),
    .frame_id(pend_id_q), .hit(fl_hit)
  );

  can_rx_first_hit #(.N(NMB), .IW(MB_IW)) u_mb_pick (
    .hit(mb_hit), .any(mb_any), .idx(mb_sel)
  );

  can_rx_first_hit #(.N(NFLT), .IW(FL_IW)) u_fl_pick (
    .hit(fl_hit), .any(fl_any), .idx(fl_sel)
  );

  // stage 2: decision
  always_comb begin
    fifo_room = cnt_q < DEPTH_C;
    take_fifo = pend_q && fifo_room && fl_any && (cfg_fifo_first || !mb_any);
    take_mb   = pend_q && mb_any && !take_fifo;
    ovf_now   = pend_q && !fifo_room && fl_any && !mb_any;
  end

  logic             sv_q, tf_q, ovf_q;
  logic [IDX_W-1:0] idx_q;
  wire              pop_ok = fifo_pop && (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sv_q  <= 1'b0;
      tf_q  <= 1'b0;
      ovf_q <= 1'b0;
      idx_q <= '0;
      cnt_q <= '0;
    end else begin
      sv_q  <= take_fifo || take_mb;
      tf_q  <= take_fifo;
      ovf_q <= ovf_now;
      if (take_fifo)    idx_q <= IDX_W'(fl_sel);
      else if (take_mb) idx_q <= IDX_W'(mb_sel);
      cnt_q <= cnt_q + CNT_W'(take_fifo) - CNT_W'(pop_ok);
    end
  end

  assign store_valid   = sv_q;
  assign store_to_fifo = tf_q;
  assign store_index   = idx_q;
  assign fifo_overflow = ovf_q;
  assign fifo_count    = cnt_q;

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_valid && fifo_overflow));  // R8

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= DEPTH_C);  // R11

  AST_OVF_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_overflow |-> $past(fifo_count) == DEPTH_C);  // R8

  AST_FIFO_STORE_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    (store_valid && store_to_fifo) |-> $past(fifo_count) < DEPTH_C);  // R7

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (store_valid && !$past(frame_valid && frame_ready)) |=> !store_valid);  // R10
endmodule

// File: tb/can_rx_match_bench.sv
`timescale 1ns/1ps
module can_rx_match_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_fifo_first = 1'b0;
  logic        frame_valid = 1'b0;
  logic        frame_ready;
  logic [28:0] frame_id = '0;
  logic        mb_wr_en = 1'b0;
  logic [3:0]  mb_wr_idx = '0;
  logic [3:0]  mb_wr_code = '0;
  logic [28:0] mb_wr_id = '0, mb_wr_mask = '0;
  logic        flt_wr_en = 1'b0;
  logic [2:0]  flt_wr_idx = '0;
  logic        flt_wr_on = 1'b0;
  logic [28:0] flt_wr_id = '0, flt_wr_mask = '0;
  logic        fifo_pop = 1'b0;
  logic [3:0]  mb_rd_idx = '0;
  logic [3:0]  mb_rd_code;
  logic        store_valid, store_to_fifo, fifo_overflow;
  logic [3:0]  store_index;
  logic [2:0]  fifo_count;

  always #4 clk = ~clk;  // 125 MHz

  can_rx_match u_can_rx_match (
    .clk(clk), .rst_n(rst_n), .cfg_fifo_first(cfg_fifo_first),
    .frame_valid(frame_valid), .frame_ready(frame_ready), .frame_id(frame_id),
    .mb_wr_en(mb_wr_en), .mb_wr_idx(mb_wr_idx), .mb_wr_code(mb_wr_code),
    .mb_wr_id(mb_wr_id), .mb_wr_mask(mb_wr_mask),
    .flt_wr_en(flt_wr_en), .flt_wr_idx(flt_wr_idx), .flt_wr_on(flt_wr_on),
    .flt_wr_id(flt_wr_id), .flt_wr_mask(flt_wr_mask),
    .fifo_pop(fifo_pop), .mb_rd_idx(mb_rd_idx), .mb_rd_code(mb_rd_code),
    .store_valid(store_valid), .store_to_fifo(store_to_fifo),
    .store_index(store_index), .fifo_overflow(fifo_overflow),
    .fifo_count(fifo_count)
  );

  int    n_chk = 0, n_fail = 0, cycles = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  // behavioural reference model
  int          m_code [16];
  logic [28:0] m_id [16], m_mask [16];
  bit          f_on [8];
  logic [28:0] f_id [8], f_mask [8];
  int          m_cnt = 0;
  bit          m_pend = 0, m_rdy = 0;
  logic [28:0] m_pend_id = '0;
  bit          e_sv = 0, e_tf = 0, e_ovf = 0;
  int          e_idx = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin m_code[i] = 0; m_id[i] = '0; m_mask[i] = '0; end
      for (int i = 0; i < 8; i++) begin f_on[i] = 0; f_id[i] = '0; f_mask[i] = '0; end
      m_cnt = 0; m_pend = 0; m_rdy = 0; e_sv = 0; e_tf = 0; e_ovf = 0;
    end else begin
      int  mh, fh, cap;
      bit  push, pop;
      e_sv = 0; e_tf = 0; e_ovf = 0; cap = -1; push = 0;
      if (m_pend) begin
        mh = -1; fh = -1;
        for (int i = 0; i < 16; i++)
          if (mh < 0 && m_code[i] == 1 && ((m_pend_id ^ m_id[i]) & m_mask[i]) == 0) mh = i;
        for (int i = 0; i < 8; i++)
          if (fh < 0 && f_on[i] && ((m_pend_id ^ f_id[i]) & f_mask[i]) == 0) fh = i;
        if (m_cnt < 6 && fh >= 0 && (cfg_fifo_first || mh < 0)) begin
          e_sv = 1; e_tf = 1; e_idx = fh; push = 1;
        end else if (mh >= 0) begin
          e_sv = 1; e_idx = mh; cap = mh;
        end else if (m_cnt >= 6 && fh >= 0) begin
          e_ovf = 1;
        end
      end
      pop = fifo_pop && m_cnt > 0;
      m_pend = frame_valid && m_rdy;
      m_pend_id = frame_id;
      if (cap >= 0) m_code[cap] = 2;
      if (mb_wr_en) begin
        m_code[mb_wr_idx] = int'(mb_wr_code);
        m_id[mb_wr_idx] = mb_wr_id;
        m_mask[mb_wr_idx] = mb_wr_mask;
      end
      if (flt_wr_en) begin
        f_on[flt_wr_idx] = flt_wr_on;
        f_id[flt_wr_idx] = flt_wr_id;
        f_mask[flt_wr_idx] = flt_wr_mask;
      end
      m_cnt = m_cnt + int'(push) - int'(pop);
      m_rdy = 1;
    end
  end

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  // compare mid-cycle, away from both edges
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk("store_valid", int'(store_valid), int'(e_sv));
      chk("fifo_overflow", int'(fifo_overflow), int'(e_ovf));
      chk("fifo_count", int'(fifo_count), m_cnt);
      chk("frame_ready", int'(frame_ready), int'(m_rdy));
      chk("mb_rd_code", int'(mb_rd_code), m_code[mb_rd_idx]);
      if (e_sv) begin
        chk("store_to_fifo", int'(store_to_fifo), int'(e_tf));
        chk("store_index", int'(store_index), e_idx);
      end
    end
  end

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) nxt();
  endtask

  task automatic mbw(int i, int c, logic [28:0] id, logic [28:0] m);
    nxt(); mb_wr_en = 1; mb_wr_idx = 4'(i); mb_wr_code = 4'(c); mb_wr_id = id; mb_wr_mask = m;
    nxt(); mb_wr_en = 0;
  endtask

  task automatic flw(int i, bit on, logic [28:0] id, logic [28:0] m);
    nxt(); flt_wr_en = 1; flt_wr_idx = 3'(i); flt_wr_on = on; flt_wr_id = id; flt_wr_mask = m;
    nxt(); flt_wr_en = 0;
  endtask

  task automatic send(logic [28:0] id);
    nxt(); frame_valid = 1; frame_id = id;
    nxt(); frame_valid = 0;
    idle(2);
  endtask

  task automatic pop1();
    nxt(); fifo_pop = 1;
    nxt(); fifo_pop = 0;
  endtask

  localparam logic [28:0] ALL = 29'h1FFF_FFFF;

  initial begin
    // R1: reset state
    idle(3);
    rst_n = 1;
    cur_req = "R1";
    n_chk++;
    if (frame_ready !== 1'b0) begin
      n_fail++; $display("FAIL R1 frame_ready actual=%0b expected=0", frame_ready);
    end
    for (int i = 0; i < 16; i++) begin nxt(); mb_rd_idx = 4'(i); end
    idle(2);
    cur_req = "R13";  // nothing configured: frame dropped
    send(29'h55);

    // R3: matching rule, exact and partial mask
    cur_req = "R3";
    mbw(0, 1, 29'h123, ALL);
    mbw(1, 1, 29'h100, ALL & ~29'hFF);
    mb_rd_idx = 0;
    send(29'h124);
    send(29'h123);
    send(29'h1AB);

    // R9: full mailbox ignores frames until rewritten
    cur_req = "R9";
    send(29'h123);
    mbw(0, 1, 29'h123, ALL);
    send(29'h123);

    // R2: inactive, full and transmit codes never take a frame
    cur_req = "R2";
    mbw(2, 4, 29'h0, 29'h0);
    mbw(3, 0, 29'h0, 29'h0);
    mbw(4, 2, 29'h0, 29'h0);
    mb_rd_idx = 2;
    send(29'h777);

    // R4: lowest index wins
    cur_req = "R4";
    mbw(5, 1, 29'h0, 29'h0);
    mbw(9, 1, 29'h0, 29'h0);
    send(29'h777);
    send(29'h777);
    flw(6, 1, 29'h0, 29'h0);
    flw(2, 1, 29'h40, ALL);
    cfg_fifo_first = 1;
    send(29'h40);
    send(29'h41);

    // R5 / R6: scan order and fallback
    cur_req = "R5";
    mbw(5, 1, 29'h0, 29'h0);
    send(29'h88);
    flw(6, 0, 29'h0, 29'h0);
    send(29'h88);          // no filter: falls back to mailbox
    cur_req = "R6";
    cfg_fifo_first = 0;
    flw(6, 1, 29'h0, 29'h0);
    mbw(5, 1, 29'h0, 29'h0);
    send(29'h99);
    send(29'h99);          // no mailbox: falls back to FIFO

    // R10: back-to-back frames, one strobe per frame
    cur_req = "R10";
    for (int i = 0; i < 2; i++) pop1();
    cfg_fifo_first = 1;
    nxt(); frame_valid = 1; frame_id = 29'h10;
    nxt(); frame_id = 29'h11;
    nxt(); frame_valid = 0;
    idle(3);

    // R7 / R8: full FIFO
    cur_req = "R7";
    nxt(); frame_valid = 1; frame_id = 29'h20;
    idle(5);
    frame_valid = 0;
    idle(3);
    mbw(7, 1, 29'h20, ALL);
    send(29'h20);          // FIFO full: mailbox takes it, no overflow
    cur_req = "R8";
    send(29'h21);
    send(29'h22);
    cur_req = "R11";
    pop1();
    send(29'h23);

    // R11: pop on empty, pop with store in same cycle
    for (int i = 0; i < 8; i++) pop1();
    nxt(); frame_valid = 1; frame_id = 29'h30;
    nxt(); frame_valid = 0;
    pop1();
    idle(2);
    nxt(); frame_valid = 1; frame_id = 29'h31;
    nxt(); frame_valid = 0; fifo_pop = 1;
    nxt(); fifo_pop = 0;
    idle(2);

    // R12: host write collides with capture
    cur_req = "R12";
    flw(6, 0, 29'h0, 29'h0);
    mbw(8, 1, 29'h3C, ALL);
    mb_rd_idx = 8;
    nxt(); frame_valid = 1; frame_id = 29'h3C;
    nxt(); frame_valid = 0;
    mb_wr_en = 1; mb_wr_idx = 8; mb_wr_code = 4'h1; mb_wr_id = 29'h3C; mb_wr_mask = ALL;
    nxt(); mb_wr_en = 0;
    idle(2);
    send(29'h3C);

    // mixed traffic
    cur_req = "R4";
    for (int c = 0; c < 3000; c++) begin
      nxt();
      frame_valid = ($urandom % 2) == 0;
      frame_id = 29'($urandom % 8);
      fifo_pop = ($urandom % 5) == 0;
      cfg_fifo_first = ($urandom % 64) == 0 ? ~cfg_fifo_first : cfg_fifo_first;
      mb_rd_idx = 4'($urandom % 16);
      mb_wr_en = ($urandom % 6) == 0;
      mb_wr_idx = 4'($urandom % 16);
      case ($urandom % 4)
        0: mb_wr_code = 4'h0;
        1: mb_wr_code = 4'h2;
        2: mb_wr_code = 4'h4;
        default: mb_wr_code = 4'h1;
      endcase
      mb_wr_id = 29'($urandom % 8);
      mb_wr_mask = 29'($urandom % 8);
      flt_wr_en = ($urandom % 20) == 0;
      flt_wr_idx = 3'($urandom % 8);
      flt_wr_on = ($urandom % 2) == 0;
      flt_wr_id = 29'($urandom % 8);
      flt_wr_mask = 29'($urandom % 8);
    end
    nxt();
    frame_valid = 0; fifo_pop = 0; mb_wr_en = 0; flt_wr_en = 0;
    idle(4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL %s watchdog actual=%0d expected=<150000", cur_req, cycles);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule